// File: doc/BRIEF.md
# Address Region Security Permission Checker

This block decides, one bus access at a time, whether a memory access may proceed. It holds a small bank of programmable address regions. Each region has a base, a power-of-two size, an enable bit and four permission bits. For every access request it finds the region that covers the address and weighs the access direction (read or write) and the security state of the master (secure or non-secure) against that region's permissions. It returns a single permit or deny verdict. Region 0 is a fixed background region that covers every address that no other enabled region claims.

Software sets up the regions through a plain word-wide register port with a write strobe and a combinational read. The port also reports the region count, controls whether secure masters inherit non-secure rights, and holds a lockdown range and selection. While the `lock_i` input is high, that lockdown freezes chosen registers. Requests enter on a valid/ready stream and verdicts leave on a valid/ready stream. A request is accepted only when the verdict slot is empty or being drained in the same cycle (`req_ready = !rsp_valid || rsp_ready`). A verdict that has not been taken stays unchanged until `rsp_ready` is seen.

Top module: `addr_perm_checker`

## Requirements
- R1: The register at offset 0x000 reads the region count minus one in bits 3:0 and zero elsewhere. After reset, all region registers, the inversion enable and the lockdown registers read zero, `rsp_valid` is low and `req_ready` is high.
- R2: Region n has registers at fixed offsets. Its base-low register is at 0x100+0x10*n. Its base-high register is at 0x104+0x10*n; it always reads zero and ignores writes. Its attribute word is at 0x108+0x10*n, with permissions in bits 31:28, size code in bits 6:1 and enable in bit 0. Other attribute bits read zero.
- R3: A write to a base-low register stores the value with bits 14:0 forced to zero.
- R4: An enabled region n≥1 covers an address when all address bits at and above position code+1 equal the same bits of its base. Its size is 2^(code+1) bytes. A stored code below 14 is matched as code 14 (32 KB), and codes of 31 and above cover the whole space.
- R5: In the permission field, bit 3 allows secure read, bit 2 secure write, bit 1 non-secure read and bit 0 non-secure write. A non-secure access is allowed only by bit 1 (read) or bit 0 (write).
- R6: Bit 0 of the register at 0x034 is the inversion enable, and it is 0 after reset. While it is 0, a secure read is also allowed by bit 1 and a secure write by bit 0. While it is 1, secure accesses use only bits 3 and 2.
- R7: When several enabled regions cover an address, the highest-numbered one decides. Region 0 decides only when none of regions 1 and up covers the address. Region 0 stores only its permission field; its base and its other attribute bits read zero.
- R8: Writing a region's enable bit as 0 removes that region from matching and keeps its base, size code and permissions readable.
- R9: The lockdown-range register (0x008, bits 3:0 = K) and the lockdown-select register (0x00C, bit 0 = lock regions, bit 1 = lock inversion register) work only while `lock_i` is high. In that state, writes to 0x008 and 0x00C are ignored. If select bit 0 is set, writes to every region n with n+K ≥ count−1 are ignored. If select bit 1 is set, writes to 0x034 are ignored. While `lock_i` is low, all of these writes take effect.
- R10: A request accepted at a clock edge yields `rsp_valid` with its verdict after that edge, so the latency is one clock. While `rsp_valid` is high and `rsp_ready` low, `rsp_permit` holds and `req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| lock_i | input | 1 | Lockdown enforce input |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Access request accepted this cycle |
| req_addr | input | 32 | Access address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | 1 = secure master |
| rsp_valid | output | 1 | Verdict valid |
| rsp_ready | input | 1 | Verdict consumer ready |
| rsp_permit | output | 1 | 1 = allowed, 0 = denied |

## Verification
Accesses are aimed at regions that are nested and overlapping, at region edges, and at the background region. Each of these cases is tried in all four direction/security combinations. This separates the priority choice from the permission-bit selection and from secure inheritance. The same addresses are then tried again with inversion on, with a region disabled, and with a region given a code below 14. The results tell apart the inherit rule, the enable bit and the code clamp. Lockdown writes are aimed at locked and unlocked regions and at the lockdown and inversion registers themselves. A stalled verdict is held while a conflicting request waits, which shows that a waiting request cannot overwrite a verdict that has not been taken.

// File: rtl/apc_pkg.sv
package apc_pkg;
  localparam int ADDR_W   = 32;
  localparam int ALIGN_W  = 15;
  localparam int MIN_CODE = 14;

  typedef struct packed {
    logic [ADDR_W-1:ALIGN_W] base;
    logic [3:0]              perm;
    logic [5:0]              code;
    logic                    en;
  } region_t;

  // Region cover test: address bits at and above code+1 equal the base.
  function automatic logic covers(input logic [ADDR_W-1:0] a,
                                  input logic [ADDR_W-1:ALIGN_W] b,
                                  input logic [5:0] code);
    logic [6:0]        sh;
    logic [ADDR_W-1:0] mask;
    sh   = (code < 6'(MIN_CODE)) ? 7'(MIN_CODE + 1) : 7'(code) + 7'd1;
    mask = (sh >= 7'(ADDR_W)) ? '0 : ({ADDR_W{1'b1}} << sh);
    return ((a ^ {b, {ALIGN_W{1'b0}}}) & mask) == '0;
  endfunction

  // perm: [3] sec read, [2] sec write, [1] ns read, [0] ns write
  function automatic logic allowed(input logic [3:0] perm, input logic wr,
                                   input logic sec, input logic inv_en);
    logic ns_ok;
    ns_ok = wr ? perm[0] : perm[1];
    if (!sec) return ns_ok;
    return (wr ? perm[2] : perm[3]) | (!inv_en & ns_ok);
  endfunction
endpackage

// File: rtl/apc_region_bank.sv
module apc_region_bank
  import apc_pkg::*;
#(
  parameter int NUM_REGIONS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [11:0]   addr,
  input  logic [31:0]   wdata,
  input  logic          lock_i,
  output region_t       regions [NUM_REGIONS],
  output logic          inv_en,
  output logic [3:0]    lk_range,
  output logic [1:0]    lk_sel,
  output logic [31:0]   rdata
);
  localparam logic [11:0] OFS_CFG   = 12'h000;
  localparam logic [11:0] OFS_RANGE = 12'h008;
  localparam logic [11:0] OFS_SEL   = 12'h00C;
  localparam logic [11:0] OFS_INV   = 12'h034;
  localparam logic [3:0]  WORD_BASE = 4'h0;
  localparam logic [3:0]  WORD_HIGH = 4'h4;
  localparam logic [3:0]  WORD_ATTR = 4'h8;

  logic                   rspace;
  logic [3:0]             ridx;
  logic [3:0]             rword;
  logic [NUM_REGIONS-1:0] frozen;

  assign rspace = (addr[11:8] == 4'h1);
  assign ridx   = addr[7:4];
  assign rword  = addr[3:0];

  for (genvar n = 0; n < NUM_REGIONS; n++) begin : g_reg
    assign frozen[n] = lock_i && lk_sel[0] &&
                       ((32'(lk_range) + 32'(n)) >= 32'(NUM_REGIONS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regions[n] <= '0;
      end else if (we && rspace && ridx == 4'(n) && !frozen[n]) begin
        if (rword == WORD_ATTR) begin
          regions[n].perm <= wdata[31:28];
          if (n != 0) begin
            regions[n].code <= wdata[6:1];
            regions[n].en   <= wdata[0];
          end
        end else if (rword == WORD_BASE && n != 0) begin
          regions[n].base <= wdata[ADDR_W-1:ALIGN_W];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inv_en   <= 1'b0;
      lk_range <= '0;
      lk_sel   <= '0;
    end else if (we) begin
      if (addr == OFS_RANGE && !lock_i) lk_range <= wdata[3:0];
      if (addr == OFS_SEL && !lock_i)   lk_sel   <= wdata[1:0];
      if (addr == OFS_INV && !(lock_i && lk_sel[1])) inv_en <= wdata[0];
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      OFS_CFG:   rdata[3:0] = 4'(NUM_REGIONS - 1);
      OFS_RANGE: rdata[3:0] = lk_range;
      OFS_SEL:   rdata[1:0] = lk_sel;
      OFS_INV:   rdata[0]   = inv_en;
      default: begin
        for (int n = 0; n < NUM_REGIONS; n++) begin
          if (rspace && ridx == 4'(n)) begin
            if (rword == WORD_BASE)
              rdata = {regions[n].base, {ALIGN_W{1'b0}}};
            else if (rword == WORD_ATTR)
              rdata = {regions[n].perm, 21'd0, regions[n].code, regions[n].en};
          end
        end
      end
    endcase
  end
endmodule

// File: rtl/apc_region_match.sv
module apc_region_match
  import apc_pkg::*;
#(
  parameter int NUM_REGIONS = 4
) (
  input  region_t             regions [NUM_REGIONS],
  input  logic [ADDR_W-1:0]   addr,
  output logic [3:0]          perm
);
  logic [NUM_REGIONS-1:0] hit;

  assign hit[0] = 1'b1;
  for (genvar n = 1; n < NUM_REGIONS; n++) begin : g_hit
    assign hit[n] = regions[n].en && covers(addr, regions[n].base, regions[n].code);
  end

  // Ascending scan so the highest-numbered hit is the one that sticks.
  always_comb begin
    perm = regions[0].perm;
    for (int n = 1; n < NUM_REGIONS; n++)
      if (hit[n]) perm = regions[n].perm;
  end
endmodule

// File: rtl/addr_perm_checker.sv
module addr_perm_checker
  import apc_pkg::*;
#(
  parameter int NUM_REGIONS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [11:0] reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        lock_i,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_addr,
  input  logic        req_write,
  input  logic        req_secure,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic        rsp_permit
);
  region_t    regions [NUM_REGIONS];
  logic       inv_en;
  logic [3:0] lk_range;
  logic [1:0] lk_sel;
  logic [3:0] win_perm;

  apc_region_bank #(.NUM_REGIONS(NUM_REGIONS)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .lock_i(lock_i), .regions(regions), .inv_en(inv_en), .lk_range(lk_range),
    .lk_sel(lk_sel), .rdata(reg_rdata)
  );

  apc_region_match #(.NUM_REGIONS(NUM_REGIONS)) u_match (
    .regions(regions), .addr(req_addr), .perm(win_perm)
  );

  assign req_ready = !rsp_valid || rsp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_permit <= 1'b0;
    end else if (req_valid && req_ready) begin
      rsp_valid  <= 1'b1;
      rsp_permit <= allowed(win_perm, req_write, req_secure, inv_en);
    end else if (rsp_ready) begin
      rsp_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/apc_checker.sv
module apc_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_we,
  input logic [11:0] reg_addr,
  input logic        lock_i,
  input logic        req_valid,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic        rsp_permit,
  input logic [3:0]  lk_range,
  input logic [1:0]  lk_sel
);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_permit));

  a_r10_stall: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);

  a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);

  a_r9_range_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    lock_i && reg_we && reg_addr == 12'h008 |=> $stable(lk_range));

  a_r9_select_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    lock_i && reg_we && reg_addr == 12'h00C |=> $stable(lk_sel));
endmodule

bind addr_perm_checker apc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .lock_i(lock_i),
  .req_valid(req_valid), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_permit(rsp_permit), .lk_range(lk_range), .lk_sel(lk_sel)
);

// File: tb/addr_perm_checker_tb.sv
module addr_perm_checker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        lock_i = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        req_secure = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_permit;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  addr_perm_checker u_dut (.*);

  // {addr, write, secure, expected permit}
  localparam int NV = 14;
  localparam logic [34:0] VEC [NV] = '{
    {32'h0001_0004, 1'b0, 1'b0, 1'b1},  // R7 r1 ns read
    {32'h0001_0004, 1'b1, 1'b0, 1'b0},  // R5 r1 ns write denied
    {32'h0001_0004, 1'b1, 1'b1, 1'b0},  // R6 no SW, no NW
    {32'h0001_0004, 1'b0, 1'b1, 1'b1},  // R5 secure read
    {32'h0001_8000, 1'b0, 1'b0, 1'b0},  // R7 r2 beats r1
    {32'h0001_8000, 1'b1, 1'b0, 1'b1},  // R7 r2 ns write
    {32'h0001_FFFC, 1'b1, 1'b1, 1'b1},  // R6 inherit NW
    {32'h0002_0000, 1'b0, 1'b0, 1'b1},  // R4 past r1 edge -> r0
    {32'h0002_0000, 1'b1, 1'b0, 1'b0},  // R7 r0 no NW
    {32'h0002_0000, 1'b0, 1'b1, 1'b1},  // R6 inherit NR from r0
    {32'h8000_0000, 1'b1, 1'b1, 1'b1},  // R4 2 GB region
    {32'hFFFF_FFFC, 1'b0, 1'b0, 1'b0},  // R5 secure-only region
    {32'h7FFF_FFFC, 1'b0, 1'b0, 1'b1},  // R4 just below r3
    {32'h0000_FFFC, 1'b0, 1'b0, 1'b1}   // R4 just below r1
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a; #1;
    check(reg_rdata, exp, tag);
  endtask

  task automatic access(input logic [31:0] a, input logic w, input logic s,
                        input logic exp, input string tag);
    req_addr = a; req_write = w; req_secure = s; req_valid = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0;
    check({30'd0, rsp_valid, rsp_permit}, {30'd0, 1'b1, exp}, tag);
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check({31'd0, rsp_valid}, 32'd0, "R1 reset rsp_valid");
    check({31'd0, req_ready}, 32'd1, "R1 reset req_ready");
    rst_n = 1'b1;
    @(posedge clk); #1;
    rd(12'h000, 32'd3, "R1 config count");
    rd(12'h118, 32'd0, "R1 reset attr");
    rd(12'h034, 32'd0, "R1 reset inversion");

    // Program regions
    wr(12'h108, 32'hFFFF_FFFF);
    rd(12'h108, 32'hF000_0000, "R7 region0 perm only");
    wr(12'h100, 32'hFFFF_FFFF);
    rd(12'h100, 32'd0, "R7 region0 base zero");
    wr(12'h108, 32'h2000_0000);
    wr(12'h110, 32'h0001_7FFF);
    rd(12'h110, 32'h0001_0000, "R3 base low bits cleared");
    wr(12'h114, 32'h1234_5678);
    rd(12'h114, 32'd0, "R2 base-high reads zero");
    wr(12'h118, 32'hA000_001F);
    rd(12'h118, 32'hA000_001F, "R2 attr layout");
    wr(12'h120, 32'h0001_8000);
    wr(12'h128, 32'h1000_001D);
    wr(12'h130, 32'h8000_0000);
    wr(12'h138, 32'hC000_003D);
    rd(12'h138, 32'hC000_003D, "R2 attr region3");

    for (int i = 0; i < NV; i++)
      access(VEC[i][34:3], VEC[i][2], VEC[i][1], VEC[i][0], $sformatf("R5 vector %0d", i));

    // R4 code below 14 matches as 32 KB
    wr(12'h128, 32'h1000_0005);
    access(32'h0001_8010, 1'b1, 1'b0, 1'b1, "R4 small code clamp");
    wr(12'h128, 32'h1000_001D);

    // R6 inversion on
    wr(12'h034, 32'd1);
    rd(12'h034, 32'd1, "R6 inversion readback");
    access(32'h0001_FFFC, 1'b1, 1'b1, 1'b0, "R6 no inherit write");
    access(32'h0002_0000, 1'b0, 1'b1, 1'b0, "R6 no inherit read");
    access(32'h0002_0000, 1'b0, 1'b0, 1'b1, "R6 ns unaffected");

    // R8 disable region 2
    wr(12'h128, 32'h1000_001C);
    rd(12'h128, 32'h1000_001C, "R8 fields kept");
    access(32'h0001_8000, 1'b0, 1'b0, 1'b1, "R8 disabled region skipped");

    // R9 lockdown
    wr(12'h008, 32'd0);
    wr(12'h00C, 32'd3);
    lock_i = 1'b1;
    wr(12'h138, 32'd0);
    rd(12'h138, 32'hC000_003D, "R9 locked region write ignored");
    wr(12'h008, 32'd5);
    rd(12'h008, 32'd0, "R9 range write ignored");
    wr(12'h00C, 32'd0);
    rd(12'h00C, 32'd3, "R9 select write ignored");
    wr(12'h034, 32'd0);
    rd(12'h034, 32'd1, "R9 inversion locked");
    wr(12'h118, 32'hA000_001E);
    rd(12'h118, 32'hA000_001E, "R9 unlocked region writable");
    access(32'h0001_0004, 1'b0, 1'b1, 1'b0, "R9 r1 off, r0 no SR");
    lock_i = 1'b0;
    wr(12'h138, 32'd0);
    rd(12'h138, 32'd0, "R9 writes after unlock");

    // R10 back-pressure
    rsp_ready = 1'b0;
    access(32'h0002_0000, 1'b0, 1'b0, 1'b1, "R10 latency");
    check({31'd0, req_ready}, 32'd0, "R10 ready low while stalled");
    req_addr = 32'h0002_0000; req_write = 1'b1; req_secure = 1'b0; req_valid = 1'b1;
    @(posedge clk); #1;
    @(posedge clk); #1;
    check({30'd0, rsp_valid, rsp_permit}, 32'd3, "R10 verdict held");
    rsp_ready = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0;
    check({30'd0, rsp_valid, rsp_permit}, 32'd2, "R10 waiting request taken");
    @(posedge clk); #1;
    check({31'd0, rsp_valid}, 32'd0, "R10 drained");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule